// File: doc/BRIEF.md
# Chunk Hamming Parity Generator

This block computes a three-byte single-error-correcting parity code over a data chunk of 256 bytes. The bytes arrive one per beat on an 8-bit input qualified by a valid strobe. A beat counter inside the block assigns each byte its index, so the arrival order sets the index. As each byte is accepted, the block folds it into two accumulators. The first is a column part that records which bit positions inside the bytes are set. The second is a row part that records, for bytes of odd parity, whether each bit of their index is 0 or 1.

When the 256th byte is accepted, the block inverts the accumulated code and forces the two lowest bits of the first byte high. It then presents the three code bytes with a one-cycle done strobe and holds them until the next start pulse. A page larger than one chunk is handled by issuing a start pulse before each chunk and concatenating the triples in chunk order. A start pulse clears the counter, both accumulators and the outputs. A chunk that is only partly delivered can therefore be abandoned at any beat.

Top module: `ecc256_gen`

## Requirements
- R1: After synchronous active-high reset, `done` is 0 and all three code bytes read 0x00.
- R2: Code byte 0 bits 7..2 are the inverted XOR, over all bytes of the chunk, of these data bit groups. Bit 2 takes bits {0,2,4,6} and bit 3 takes {1,3,5,7}. Bit 4 takes {0,1,4,5} and bit 5 takes {2,3,6,7}. Bit 6 takes {0,1,2,3} and bit 7 takes {4,5,6,7}.
- R3: For a byte of odd parity at index i and index bit k in 0..3, the row accumulator of code byte 2 toggles bit 2k when i[k] is 0 and bit 2k+1 when i[k] is 1.
- R4: For index bit k in 4..7, the same paired toggle is applied to code byte 1 at bits 2(k-4) and 2(k-4)+1.
- R5: Bytes of even parity leave code bytes 1 and 2 untouched, so a chunk made only of such bytes yields 0xFF in both.
- R6: The presented code is the bitwise inverse of the accumulators, and code byte 0 bits 1:0 always read 2'b11 when `done` is high.
- R7: `done` is high for exactly one cycle, in the cycle after the edge that accepts the 256th byte, and never earlier.
- R8: The code bytes stay unchanged from the `done` cycle until the next start or reset.
- R9: A start pulse clears the index counter, the accumulators, `done` and the code bytes, so a partly delivered chunk has no effect on the next one.
- R10: Beats with `in_valid` low are ignored and do not advance the index.
- R11: After the 256th byte, further valid bytes are ignored until the next start: no new `done` and no change to the code.
- R12: A byte presented with `in_valid` in the same cycle as `start` is dropped, and the next accepted byte gets index 0.
- R13: Chunks separated only by a start pulse each produce their own code, independent of the previous chunk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear pulse that begins a new chunk |
| in_valid | input | 1 | Qualifies `in_byte` this cycle |
| in_byte | input | 8 | Data byte |
| done | output | 1 | One-cycle strobe: code bytes are valid |
| ecc_b0 | output | 8 | Code byte 0 (column parity, bits 1:0 forced high) |
| ecc_b1 | output | 8 | Code byte 1 (row parity for index bits 7..4) |
| ecc_b2 | output | 8 | Code byte 2 (row parity for index bits 3..0) |

## Verification
The bench uses a single set bit at index 0 and another at index 255. A design that swapped the even and odd bit of a row pair, or that put the high index bits into the wrong byte, would return the wrong code byte 1 or 2 for these. A chunk of bytes that each have even parity exposes a design that updates the row parity on every byte and not only on odd-parity bytes. Other tests use idle beats between bytes, a start arriving together with a valid byte, a restart in mid-chunk, and surplus bytes after completion. An off-by-one or stale counter in any of these would raise `done` early or late, or produce a code shifted by one index. Every chunk is compared with a model computed in the bench.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;
   // fixed code geometry: one byte of column parity, two bytes of row parity
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned COL_W    = 6;
   localparam int unsigned ROW_W    = 16;
   localparam int unsigned MAX_IDX_W = ROW_W / 2;

   typedef logic [COL_W-1:0] col_par_t;
   typedef logic [ROW_W-1:0] row_par_t;

   typedef struct packed {
      logic [BYTE_W-1:0] b2;
      logic [BYTE_W-1:0] b1;
      logic [BYTE_W-1:0] b0;
   } ecc_code_t;
endpackage

// File: rtl/ecc256_col_mix.sv
module ecc256_col_mix
   import ecc256_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   output col_par_t          col,
   output logic              odd
);
   localparam int unsigned LVLS = $clog2(DATA_W);

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("ecc256_col_mix: DATA_W must be 8 for this code layout");
   end

   // level l: even slot collects bit positions with pos[l]==0, odd slot pos[l]==1
   for (genvar l = 0; l < LVLS; l++) begin : g_lvl
      logic lo_acc, hi_acc;
      always_comb begin
         lo_acc = 1'b0;
         hi_acc = 1'b0;
         for (int p = 0; p < DATA_W; p++) begin
            if (((p >> l) & 1) == 0) lo_acc = lo_acc ^ data[p];
            else                     hi_acc = hi_acc ^ data[p];
         end
      end
      assign col[2*l]   = lo_acc;
      assign col[2*l+1] = hi_acc;
   end

   assign odd = ^data;
endmodule

// File: rtl/ecc256_row_mix.sv
module ecc256_row_mix
   import ecc256_pkg::*;
#(
   parameter int unsigned IDX_W = 8
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             odd,
   output row_par_t         row
);
   logic [2*IDX_W-1:0] pairs;

   for (genvar k = 0; k < IDX_W; k++) begin : g_pair
      assign pairs[2*k]   = odd & ~idx[k];
      assign pairs[2*k+1] = odd &  idx[k];
   end

   if (2*IDX_W == ROW_W) begin : g_full
      assign row = pairs;
   end else begin : g_pad
      assign row = {{(ROW_W-2*IDX_W){1'b0}}, pairs};
   end
endmodule

// File: rtl/ecc256_seq.sv
module ecc256_seq #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             in_valid,
   output logic             accept,
   output logic             last,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

   logic open_q;

   assign accept = in_valid & open_q & ~start;
   assign last   = accept & (idx == IDX_LAST);

   always_ff @(posedge clk) begin
      if (rst || start) begin
         idx    <= '0;
         open_q <= 1'b1;
      end else if (accept) begin
         idx <= idx + 1'b1;
         if (last) open_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc256_gen.sv
module ecc256_gen
   import ecc256_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              done,
   output logic [BYTE_W-1:0] ecc_b0,
   output logic [BYTE_W-1:0] ecc_b1,
   output logic [BYTE_W-1:0] ecc_b2
);
   localparam int unsigned CHUNK_BYTES = 1 << IDX_W;

   if (IDX_W == 0 || IDX_W > MAX_IDX_W) begin : g_bad_idx
      $error("ecc256_gen: IDX_W must be 1..%0d", MAX_IDX_W);
   end
   if (CHUNK_BYTES < 2) begin : g_bad_chunk
      $error("ecc256_gen: chunk too small");
   end

   logic             accept, last, odd;
   logic [IDX_W-1:0] idx;
   col_par_t         col_t, col_acc, col_nxt;
   row_par_t         row_t, row_acc, row_nxt;
   ecc_code_t        code_q;

   ecc256_seq #(.IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .in_valid (in_valid),
      .accept   (accept),
      .last     (last),
      .idx      (idx)
   );

   ecc256_col_mix #(.DATA_W(DATA_W)) u_col (
      .data (in_byte),
      .col  (col_t),
      .odd  (odd)
   );

   ecc256_row_mix #(.IDX_W(IDX_W)) u_row (
      .idx (idx),
      .odd (odd),
      .row (row_t)
   );

   assign col_nxt = col_acc ^ col_t;
   assign row_nxt = row_acc ^ row_t;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         col_acc <= '0;
         row_acc <= '0;
         done    <= 1'b0;
         code_q  <= '0;
      end else begin
         done <= last;
         if (accept) begin
            col_acc <= col_nxt;
            row_acc <= row_nxt;
         end
         if (last) begin
            code_q.b0 <= {~col_nxt, 2'b11};
            code_q.b1 <= ~row_nxt[ROW_W-1:ROW_W/2];
            code_q.b2 <= ~row_nxt[ROW_W/2-1:0];
         end
      end
   end

   assign ecc_b0 = code_q.b0;
   assign ecc_b1 = code_q.b1;
   assign ecc_b2 = code_q.b2;
endmodule

// File: rtl/ecc256_chk.sv
module ecc256_chk (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       in_valid,
   input logic       done,
   input logic [7:0] ecc_b0,
   input logic [7:0] ecc_b1,
   input logic [7:0] ecc_b2
);
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                                 // R7
   AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(in_valid) && !$past(start)));                    // R7
   AST_LOW_BITS_SET: assert property (@(posedge clk) disable iff (rst)
      done |-> (ecc_b0[1:0] == 2'b11));                                // R6
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !start |=> (done || $stable({ecc_b2, ecc_b1, ecc_b0})));         // R8
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
      start |=> (!done && {ecc_b2, ecc_b1, ecc_b0} == 24'h0));         // R9
endmodule

bind ecc256_gen ecc256_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .in_valid (in_valid),
   .done     (done),
   .ecc_b0   (ecc_b0),
   .ecc_b1   (ecc_b1),
   .ecc_b2   (ecc_b2)
);

// File: tb/tb_ecc256_gen.sv
module tb_ecc256_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       done;
   logic [7:0] ecc_b0, ecc_b1, ecc_b2;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [7:0]  chunk [256];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   ecc256_gen dut (
      .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_byte(in_byte),
      .done(done), .ecc_b0(ecc_b0), .ecc_b1(ecc_b1), .ecc_b2(ecc_b2)
   );

   function automatic logic [23:0] code_now();
      return {ecc_b2, ecc_b1, ecc_b0};
   endfunction

   // model built from the requirements: returns {b2, b1, b0}
   function automatic logic [23:0] model_code();
      logic [7:0] b0 = 8'h00, b1 = 8'h00, b2 = 8'h00;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] d = chunk[i];
         b0[2] ^= d[0] ^ d[2] ^ d[4] ^ d[6];
         b0[3] ^= d[1] ^ d[3] ^ d[5] ^ d[7];
         b0[4] ^= d[0] ^ d[1] ^ d[4] ^ d[5];
         b0[5] ^= d[2] ^ d[3] ^ d[6] ^ d[7];
         b0[6] ^= d[0] ^ d[1] ^ d[2] ^ d[3];
         b0[7] ^= d[4] ^ d[5] ^ d[6] ^ d[7];
         if (^d) begin
            for (int k = 0; k < 4; k++) begin
               if (i[k]) b2[2*k+1] ^= 1'b1; else b2[2*k] ^= 1'b1;
               if (i[k+4]) b1[2*k+1] ^= 1'b1; else b1[2*k] ^= 1'b1;
            end
         end
      end
      b0 = ~b0; b1 = ~b1; b2 = ~b2;
      b0[1:0] = 2'b11;
      return {b2, b1, b0};
   endfunction

   function automatic logic [7:0] next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[7:0] ^ lfsr[15:8];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1; in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   // streams chunk[], optional idle beat every gap bytes, then checks done and code
   task automatic feed_chunk(input int gap, input string tag);
      bit early = 1'b0;
      logic [23:0] exp = model_code();
      logic [23:0] got;
      for (int i = 0; i < 256; i++) begin
         if (gap > 0 && i > 0 && (i % gap) == 0) begin
            @(negedge clk);
            if (done) early = 1'b1;
            in_valid = 1'b0; in_byte = 8'h5A;
            @(posedge clk);
         end
         @(negedge clk);
         if (done) early = 1'b1;
         in_valid = 1'b1; in_byte = chunk[i];
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 no early done", {31'd0, early}, 32'd0);
      check("R7 done after last byte", {31'd0, done}, 32'd1);
      check(tag, {8'd0, code_now()}, {8'd0, exp});
      check("R6 low bits forced", {30'd0, ecc_b0[1:0]}, 32'd3);
      got = code_now();
      @(negedge clk);
      check("R7 done single cycle", {31'd0, done}, 32'd0);
      check("R8 code held", {8'd0, code_now()}, {8'd0, got});
   endtask

   task automatic t_reset();
      check("R1 reset done", {31'd0, done}, 32'd0);
      check("R1 reset code", {8'd0, code_now()}, 32'd0);
   endtask

   task automatic t_zeros();
      for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
      pulse_start();
      feed_chunk(0, "R2 R6 all-zero chunk");
      check("R6 zero chunk inverts to ones", {8'd0, code_now()}, 32'h00FFFFFF);
   endtask

   task automatic t_single_low();
      for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
      chunk[0] = 8'h01;
      pulse_start();
      feed_chunk(0, "R3 R4 single bit at index 0");
      check("R3 byte2 even slots", {24'd0, ecc_b2}, 32'hAA);
      check("R4 byte1 even slots", {24'd0, ecc_b1}, 32'hAA);
      check("R2 column bit0", {24'd0, ecc_b0}, 32'hAB);
   endtask

   task automatic t_single_high();
      for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
      chunk[255] = 8'h80;
      pulse_start();
      feed_chunk(0, "R3 R4 single bit at index 255");
      check("R3 byte2 odd slots", {24'd0, ecc_b2}, 32'h55);
      check("R4 byte1 odd slots", {24'd0, ecc_b1}, 32'h55);
   endtask

   task automatic t_even_only();
      for (int i = 0; i < 256; i++) begin
         logic [6:0] v = 7'(i * 37 + 11);
         chunk[i] = {v, ^v};
      end
      pulse_start();
      feed_chunk(0, "R5 R2 even-parity chunk");
      check("R5 byte1 untouched", {24'd0, ecc_b1}, 32'hFF);
      check("R5 byte2 untouched", {24'd0, ecc_b2}, 32'hFF);
   endtask

   task automatic t_random_gaps();
      for (int i = 0; i < 256; i++) chunk[i] = next_rand();
      pulse_start();
      feed_chunk(7, "R10 R2 R3 R4 random chunk with idle beats");
      for (int i = 0; i < 256; i++) chunk[i] = 8'(i);
      pulse_start();
      feed_chunk(3, "R10 ramp chunk with idle beats");
   endtask

   task automatic t_restart();
      pulse_start();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_byte = next_rand();
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 no done on partial chunk", {31'd0, done}, 32'd0);
      for (int i = 0; i < 256; i++) chunk[i] = next_rand();
      pulse_start();
      check("R9 start clears code", {8'd0, code_now()}, 32'd0);
      feed_chunk(0, "R9 chunk after abandoned one");
   endtask

   task automatic t_overrun();
      logic [23:0] held;
      bit extra_done = 1'b0;
      for (int i = 0; i < 256; i++) chunk[i] = next_rand();
      pulse_start();
      feed_chunk(0, "R11 chunk before surplus bytes");
      held = code_now();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (done) extra_done = 1'b1;
         in_valid = 1'b1; in_byte = 8'hC3 + 8'(i);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (done) extra_done = 1'b1;
      check("R11 no done from surplus", {31'd0, extra_done}, 32'd0);
      check("R11 code unchanged by surplus", {8'd0, code_now()}, {8'd0, held});
   endtask

   task automatic t_start_with_valid();
      for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
      @(negedge clk);
      start = 1'b1; in_valid = 1'b1; in_byte = 8'h01;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      feed_chunk(0, "R12 byte with start dropped");
   endtask

   task automatic t_back_to_back();
      logic [23:0] first;
      for (int i = 0; i < 256; i++) chunk[i] = next_rand();
      pulse_start();
      feed_chunk(0, "R13 first chunk");
      first = code_now();
      for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
      chunk[200] = 8'h10;
      pulse_start();
      feed_chunk(0, "R13 second chunk independent");
      check("R13 second differs from first", {31'd0, code_now() == first}, 32'd0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_zeros();
      t_single_low();
      t_single_high();
      t_even_only();
      t_random_gaps();
      t_restart();
      t_overrun();
      t_start_with_valid();
      t_back_to_back();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule